// File: doc/BRIEF.md
# Output compare and PWM channel

This block is the output half of one timer channel. Each clock it looks at the count value supplied by a separate time base. It holds a compare value, optionally behind a preload stage, and compares that value against the count. A 3-bit mode selects how the active-high reference waveform reacts. The mode can hold the waveform, set it, clear it or toggle it on a match, force it to a fixed level, or produce one of two edge-aligned PWM shapes.

A polarity bit and an enable then turn the reference into the pin value and its output-enable. A sticky match flag records every compare hit, whatever the mode.

The time base tells the block when a new count is valid with `tick_i`. It reports its terminal value with `reload_i`, and signals an update event with `update_i`. All state changes are registered. The reference and the flag change on the clock edge that samples the triggering inputs. The pin follows the registered reference combinationally.

Top module: `oc_channel`

## Requirements
- R1: After reset, `ref_o` and `flag_o` are 0, and the active compare value is 0.
- R2: Mode 3'b001 sets the reference to 1, and mode 3'b010 clears it to 0, at the edge that samples `tick_i`=1 with `cnt_i` equal to the active compare value. Otherwise the reference is unchanged.
- R3: Mode 3'b011 inverts the reference at each such match and holds it otherwise.
- R4: Mode 3'b000 holds the reference. In modes 3'b000 to 3'b101 an update event never alters the reference.
- R5: Mode 3'b100 drives the reference to 0 and mode 3'b101 drives it to 1 at the next edge. Compare matches still set the flag in both modes.
- R6: Mode 3'b110 registers reference = (`cnt_i` < active compare) at every edge.
- R7: In mode 3'b110, an active compare of 0 keeps the reference at 0. An active compare above `reload_i` keeps it at 1 while the count stays within the reload value.
- R8: Mode 3'b111 registers reference = (`cnt_i` >= active compare) at every edge.
- R9: With `preload_en_i`=1, a write lands only in the preload register. The active compare value takes the preload contents at an edge that samples `update_i`=1, and is otherwise stable. A write and an update in the same cycle move the old preload contents.
- R10: With `preload_en_i`=0, a write loads the active compare value at the same edge.
- R11: `flag_o` is set by a tick whose count equals the active compare value. If the active compare exceeds `reload_i`, a tick whose count equals `reload_i` sets it instead. `flag_o` stays set until `flag_clr_i`, and a set in the same cycle wins over a clear.
- R12: When `out_en_i`=1, `pin_oe_o`=1 and `pin_o` = `ref_o` XOR `polarity_i`. When `out_en_i`=0, both `pin_o` and `pin_oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Current count from the time base |
| tick_i | input | 1 | Count value is new this cycle |
| reload_i | input | CNT_W | Active reload (terminal count) value |
| update_i | input | 1 | Update event |
| cmp_wr_i | input | 1 | Compare value write strobe |
| cmp_wdata_i | input | CNT_W | Compare value write data |
| preload_en_i | input | 1 | Compare preload enable |
| mode_i | input | 3 | Reference mode |
| polarity_i | input | 1 | 1 inverts the pin relative to the reference |
| out_en_i | input | 1 | Pin output enable |
| flag_clr_i | input | 1 | Clears the match flag |
| ref_o | output | 1 | Active-high reference waveform |
| pin_o | output | 1 | Pin value |
| pin_oe_o | output | 1 | Pin output-enable |
| flag_o | output | 1 | Sticky compare match flag |

## Verification
The hardest cases involve the preload stage. One is a write and an update event landing in the same cycle: the active compare must pick up the old preload contents, not the new data. The other is the overflow substitute for the flag, which only appears when the active compare sits above the reload value.

The bench runs its own wrapping counter with a small reload value. It fires updates at the wrap and scatters compare writes with `$urandom`, so coincident writes and updates occur often. Writes draw compare values from a range that reaches past the reload value and includes 0, so the PWM boundaries and the overflow flag path are exercised under every mode and preload setting. Directed sequences also force each of these cases once.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [2:0] {
    OCM_FROZEN   = 3'd0,
    OCM_SET      = 3'd1,
    OCM_CLEAR    = 3'd2,
    OCM_TOGGLE   = 3'd3,
    OCM_FORCE_LO = 3'd4,
    OCM_FORCE_HI = 3'd5,
    OCM_PWM_A    = 3'd6,
    OCM_PWM_B    = 3'd7
  } oc_mode_e;
endpackage

// File: rtl/oc_cmp_store.sv
module oc_cmp_store #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             preload_en_i,
  input  logic             update_i,
  output logic [CNT_W-1:0] active_o
);
  logic [CNT_W-1:0] pre_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_i) pre_q <= wdata_i;
      // direct write wins; otherwise update moves the old preload contents
      if (wr_i && !preload_en_i) act_q <= wdata_i;
      else if (update_i)         act_q <= pre_q;
    end
  end

  assign active_o = act_q;

  assert_direct_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !preload_en_i) |=> (active_o == $past(wdata_i)));
  assert_preload_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preload_en_i && !update_i) |=> $stable(active_o));
endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
  import oc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  oc_mode_e         mode_i,
  input  logic             flag_clr_i,
  output logic             ref_o,
  output logic             flag_o
);
  logic ref_q, ref_d, flag_q;
  logic hit, top_hit, below;

  assign hit     = tick_i && (cnt_i == cmp_i);
  assign top_hit = tick_i && (cmp_i > reload_i) && (cnt_i == reload_i);
  assign below   = cnt_i < cmp_i;

  always_comb begin
    ref_d = ref_q;
    unique case (mode_i)
      OCM_FROZEN:   ref_d = ref_q;
      OCM_SET:      if (hit) ref_d = 1'b1;
      OCM_CLEAR:    if (hit) ref_d = 1'b0;
      OCM_TOGGLE:   if (hit) ref_d = !ref_q;
      OCM_FORCE_LO: ref_d = 1'b0;
      OCM_FORCE_HI: ref_d = 1'b1;
      OCM_PWM_A:    ref_d = below;
      OCM_PWM_B:    ref_d = !below;
      default:      ref_d = ref_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      ref_q <= ref_d;
      if (hit || top_hit) flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign ref_o  = ref_q;
  assign flag_o = flag_q;

  assert_frozen_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OCM_FROZEN) |=> $stable(ref_o));
  assert_force_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OCM_FORCE_HI) |=> ref_o);
  assert_force_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OCM_FORCE_LO) |=> !ref_o);
  assert_pwm_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OCM_PWM_A && cmp_i == '0) |=> !ref_o);
  assert_pwm_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OCM_PWM_A && cmp_i > reload_i && cnt_i <= reload_i) |=> ref_o);
  assert_flag_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);
  assert_flag_match_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i == cmp_i) |=> flag_o);
endmodule

// File: rtl/oc_pin_drv.sv
module oc_pin_drv (
  input  logic ref_i,
  input  logic polarity_i,
  input  logic en_i,
  output logic pin_o,
  output logic oe_o
);
  assign oe_o  = en_i;
  assign pin_o = en_i & (ref_i ^ polarity_i);
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             update_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic             preload_en_i,
  input  logic [2:0]       mode_i,
  input  logic             polarity_i,
  input  logic             out_en_i,
  input  logic             flag_clr_i,
  output logic             ref_o,
  output logic             pin_o,
  output logic             pin_oe_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] cmp_act;
  oc_mode_e         mode;

  assign mode = oc_mode_e'(mode_i);

  oc_cmp_store #(.CNT_W(CNT_W)) i_store (
    .clk_i, .rst_ni,
    .wr_i(cmp_wr_i), .wdata_i(cmp_wdata_i),
    .preload_en_i, .update_i,
    .active_o(cmp_act)
  );

  oc_ref_gen #(.CNT_W(CNT_W)) i_ref (
    .clk_i, .rst_ni,
    .cnt_i, .tick_i, .reload_i,
    .cmp_i(cmp_act), .mode_i(mode), .flag_clr_i,
    .ref_o, .flag_o
  );

  oc_pin_drv i_pin (
    .ref_i(ref_o), .polarity_i, .en_i(out_en_i),
    .pin_o, .oe_o(pin_oe_o)
  );

  assert_update_no_effect_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_i && mode_i == 3'd0) |=> $stable(ref_o));
  assert_pin_off_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |-> (!pin_o && !pin_oe_o));
endmodule

// File: tb/test_oc_channel.sv
module test_oc_channel;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] cnt, rel, wd;
  logic tick, upd, wr, pe, pol, en, clr;
  logic [2:0] mode;
  logic ref_s, pin, oe, flag;

  oc_channel #(.CNT_W(W)) i_oc_channel (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .tick_i(tick), .reload_i(rel),
    .update_i(upd), .cmp_wr_i(wr), .cmp_wdata_i(wd), .preload_en_i(pe),
    .mode_i(mode), .polarity_i(pol), .out_en_i(en), .flag_clr_i(clr),
    .ref_o(ref_s), .pin_o(pin), .pin_oe_o(oe), .flag_o(flag)
  );

  int n_run = 0, n_fail = 0;
  logic [W-1:0] m_pre = '0, m_act = '0;
  logic m_ref = 1'b0, m_flag = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string mode_req(input logic [2:0] m);
    case (m)
      3'd0: return "R4";
      3'd1, 3'd2: return "R2";
      3'd3: return "R3";
      3'd4, 3'd5: return "R5";
      3'd6: return "R6";
      default: return "R8";
    endcase
  endfunction

  function automatic logic next_ref(input logic [2:0] m, input logic cur, input logic hit,
                                    input logic [W-1:0] c, input logic [W-1:0] a);
    case (m)
      3'd0: return cur;
      3'd1: return hit ? 1'b1 : cur;
      3'd2: return hit ? 1'b0 : cur;
      3'd3: return hit ? !cur : cur;
      3'd4: return 1'b0;
      3'd5: return 1'b1;
      3'd6: return c < a;
      default: return !(c < a);
    endcase
  endfunction

  // one clock: inputs already set; advance model, then check after the edge
  task automatic cyc(input string req);
    logic hit, top;
    @(posedge clk);
    hit = tick && (cnt == m_act);
    top = tick && (m_act > rel) && (cnt == rel);
    m_ref = next_ref(mode, m_ref, hit, cnt, m_act);
    if (hit || top) m_flag = 1'b1; else if (clr) m_flag = 1'b0;
    if (wr && !pe) m_act = wd; else if (upd) m_act = m_pre;
    if (wr) m_pre = wd;
    #1;
    chk(req == "" ? mode_req(mode) : req, ref_s, m_ref);
    chk(req == "" ? "R11" : req, flag, m_flag);
    chk("R12", {pin, oe}, en ? {m_ref ^ pol, 1'b1} : 2'b00);
    tick = 0; upd = 0; wr = 0; clr = 0;
  endtask

  task automatic wr_cmp(input logic [W-1:0] v, input logic p, input string req);
    wr = 1; wd = v; pe = p; cyc(req);
  endtask

  task automatic at(input logic [W-1:0] c, input string req);
    cnt = c; tick = 1; cyc(req);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] ctr;
    cnt = 0; rel = 9; wd = 0; tick = 0; upd = 0; wr = 0; pe = 0;
    pol = 0; en = 0; clr = 0; mode = 3'd0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1", {ref_s, flag, pin, oe}, 4'b0000);
    rst_n = 1'b1;
    mode = 3'd6; cnt = 0; cyc("R1");      // active compare 0 -> PWM low
    mode = 3'd0; en = 1;
    // R10 immediate write, R2 set/clear
    wr_cmp(5, 0, "R10");
    mode = 3'd1; at(4, "R2"); at(5, "R2");
    mode = 3'd2; at(6, "R2"); at(5, "R2");
    // R3 toggle
    mode = 3'd3; at(5, "R3"); at(5, "R3"); at(5, "R3");
    // R4 frozen with update
    mode = 3'd0; upd = 1; cyc("R4"); at(5, "R4");
    mode = 3'd3; upd = 1; cyc("R4");
    // R5 forced, flag still set
    clr = 1; cyc("R11");
    mode = 3'd4; at(5, "R5");
    clr = 1; mode = 3'd5; cyc("R5"); at(5, "R5");
    // R9 preload
    clr = 1; mode = 3'd1; at(0, "R9");
    mode = 3'd2; at(5, "R9");
    wr_cmp(7, 1, "R9");
    mode = 3'd1; at(7, "R9");             // active still 5: no set
    upd = 1; cyc("R9");
    at(7, "R9");                          // active now 7
    wr = 1; wd = 3; upd = 1; cyc("R9");   // moves old preload 7
    mode = 3'd2; at(7, "R9"); upd = 1; cyc("R9"); at(3, "R9");
    // R6 / R7 / R8 PWM
    pe = 0; wr_cmp(4, 0, "R6"); mode = 3'd6;
    for (int i = 0; i <= 9; i++) at(i[W-1:0], "R6");
    mode = 3'd7;
    for (int i = 0; i <= 9; i++) at(i[W-1:0], "R8");
    mode = 3'd6; wr_cmp(0, 0, "R7");
    for (int i = 0; i <= 9; i++) at(i[W-1:0], "R7");
    wr_cmp(20, 0, "R7");
    for (int i = 0; i <= 9; i++) at(i[W-1:0], "R7");
    // R11 overflow substitute, set beats clear
    clr = 1; cyc("R11");
    at(8, "R11"); at(9, "R11");
    clr = 1; cnt = 9; tick = 1; cyc("R11");
    clr = 1; cyc("R11");
    // R12 polarity / enable
    pol = 1; cyc("R12"); en = 0; cyc("R12"); en = 1; pol = 0; cyc("R12");

    // constrained random
    void'($urandom(32'd4242));
    ctr = 0;
    for (int k = 0; k < 4000; k++) begin
      if ($urandom % 200 == 0) mode = 3'($urandom);
      if ($urandom % 150 == 0) pe = 1'($urandom);
      if ($urandom % 100 == 0) pol = 1'($urandom);
      if ($urandom % 100 == 0) en = 1'($urandom);
      clr = ($urandom % 8 == 0);
      wr = ($urandom % 12 == 0);
      wd = W'($urandom % 14);
      tick = ($urandom % 3 != 0);
      if (tick) ctr = (ctr >= rel) ? '0 : ctr + 1'b1;
      cnt = ctr;
      upd = tick && (ctr == 0);
      cyc("");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule